// File: doc/BRIEF.md
# Root Port Error Status Logger

This block sits beside a root port and records the errors that reach it. Each error event carries a severity code and a 16-bit requester ID. The event may be a message from downstream or a fault the port finds in itself. The block sorts events into two categories: correctable, and uncorrectable, which takes nonfatal and fatal alike. For each category it keeps a first-error flag and a next-error flag. It stores the requester ID only for the first error of a category, and holds that ID until software clears the first flag.

Software reaches the block through a simple register port. A control register holds one interrupt enable for each severity. A status register holds the flags, which software clears by writing 1 to them. A read-only source identification register returns the two stored requester IDs. The block raises a level interrupt request while an enabled severity has its status flag set. Decoding messages from the link, and turning the request into an interrupt message, are left to neighbouring logic.

Top module: `rp_err_logger`

## Requirements
- R1: `evt_sev` code 0 is correctable, code 1 is nonfatal, and codes 2 and 3 are fatal. Nonfatal and fatal events both belong to the uncorrectable category.
- R2: An event whose category first flag is clear sets that flag and stores `evt_rid` in that category's ID field. The status register holds the correctable first flag in bit 0 and the uncorrectable first flag in bit 2.
- R3: An event whose category first flag is already set sets that category's next flag and leaves the stored ID unchanged. The correctable next flag is status bit 1 and the uncorrectable next flag is status bit 3.
- R4: Writing 1 to a status flag bit clears that bit. Writing 0 leaves it unchanged.
- R5: The control register sits at offset 0x174 and resets to 0. Bit 0 enables the correctable interrupt, bit 1 the nonfatal interrupt and bit 2 the fatal interrupt. Bits 31:3 read as 0.
- R6: The status register sits at offset 0x178. Bit 5 is set when an uncorrectable first error is nonfatal, and bit 6 is set by any fatal event. Both are cleared by writing 1, and both reset to 0. Bits 26:7 and bit 4 read as 0.
- R7: Status bits 31:27 read 1 while `msg_pair` is high and 0 while it is low.
- R8: An event that arrives on the same clock edge as a write of 1 to its category's first flag is logged as a new first error. Its ID is stored, and the next flag is not set by it.
- R9: `irq` goes high on the edge that sets an enabled status flag and stays high while any such flag is set. The pairs are status bit 0 with enable bit 0, bit 5 with enable bit 1, and bit 6 with enable bit 2. `irq` drops on the edge that clears the last one.
- R10: The source identification register sits at offset 0x17C and resets to 0. It holds the correctable ID in bits 15:0 and the uncorrectable ID in bits 31:16. Writes to it are ignored.
- R11: `reg_rdata` is registered. It shows the addressed register one cycle after `reg_rd`, with values from before that edge. It is 0 when no read is made and when the offset is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Error event strobe |
| evt_sev | input | 2 | Severity code of the event |
| evt_rid | input | 16 | Requester ID of the event |
| msg_pair | input | 1 | Port has been allocated two messages |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request level |

## Verification
An error event can land on the same edge as a software write that clears the first flag of its category. A further event can also hit a category whose first flag is already set. The bench drives an event together with a status write in a single step, for both the correctable and the uncorrectable category. It then reads the status and ID registers and judges them against a behavioural model: the event must count as a new first error, with its ID stored and no next flag raised.

// File: rtl/rpel_pkg.sv
package rpel_pkg;
  localparam int DATA_W = 32;
  localparam int RID_W  = 16;
  localparam int NCAT   = 2;   // 0 correctable, 1 uncorrectable

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2,
    SEV_FATAL_X  = 2'd3
  } sev_e;

  // status bit positions
  localparam int ST_CF  = 0;
  localparam int ST_CN  = 1;
  localparam int ST_UF  = 2;
  localparam int ST_UN  = 3;
  localparam int ST_NF  = 5;
  localparam int ST_FAT = 6;
  localparam int MSGN_LSB = 27;
  localparam int MSGN_W   = 5;
endpackage

// File: rtl/rpel_cat.sv
module rpel_cat #(
  parameter int RID_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [RID_W-1:0] rid,
  input  logic             clr_first,
  input  logic             clr_next,
  output logic             first_n,
  output logic             next_n,
  output logic             first_q,
  output logic             next_q,
  output logic [RID_W-1:0] id_q
);
  logic kept_first;
  logic take_id;

  // a first flag cleared on this edge no longer counts as set
  assign kept_first = first_q & ~clr_first;
  assign take_id    = hit & ~kept_first;
  assign first_n    = kept_first | hit;
  assign next_n     = (next_q & ~clr_next) | (hit & kept_first);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b0;
      next_q  <= 1'b0;
      id_q    <= '0;
    end else begin
      first_q <= first_n;
      next_q  <= next_n;
      if (take_id) id_q <= rid;
    end
  end
endmodule

// File: rtl/rpel_rdmux.sv
module rpel_rdmux #(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter [ADDR_W-1:0] CTRL_OFS = 12'h174,
  parameter [ADDR_W-1:0] STS_OFS  = 12'h178,
  parameter [ADDR_W-1:0] SID_OFS  = 12'h17C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ctrl_word,
  input  logic [DATA_W-1:0] sts_word,
  input  logic [DATA_W-1:0] sid_word,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == CTRL_OFS)     sel = ctrl_word;
    else if (addr == STS_OFS) sel = sts_word;
    else if (addr == SID_OFS) sel = sid_word;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
    else         rdata <= '0;
  end
endmodule

// File: rtl/rp_err_logger.sv
module rp_err_logger
  import rpel_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter [ADDR_W-1:0] CTRL_OFS = 12'h174,
  parameter [ADDR_W-1:0] STS_OFS  = 12'h178,
  parameter [ADDR_W-1:0] SID_OFS  = 12'h17C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic [1:0]        evt_sev,
  input  logic [15:0]       evt_rid,
  input  logic              msg_pair,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int NEN = 3;

  logic              ctrl_wr, sts_wr;
  logic [DATA_W-1:0] clr;
  logic [NCAT-1:0]   hit, first_n, next_n, first_q, next_q;
  logic [RID_W-1:0]  id_q [NCAT];
  logic              is_fatal, is_nonfatal;
  logic              nf_n, fat_n, nf_q, fat_q;
  logic [NEN-1:0]    en_n, en_q;
  logic [DATA_W-1:0] ctrl_word, sts_word, sid_word;
  logic [MSGN_W-1:0] msg_num;

  assign ctrl_wr = reg_wr && (reg_addr == CTRL_OFS);
  assign sts_wr  = reg_wr && (reg_addr == STS_OFS);
  assign clr     = sts_wr ? reg_wdata : '0;

  assign is_fatal    = evt_valid && evt_sev[1];
  assign is_nonfatal = evt_valid && (evt_sev == SEV_NONFATAL);
  assign hit[0]      = evt_valid && (evt_sev == SEV_COR);
  assign hit[1]      = is_fatal || is_nonfatal;

  for (genvar k = 0; k < NCAT; k++) begin : g_cat
    rpel_cat #(.RID_W(RID_W)) u_cat (
      .clk       (clk),
      .rst       (rst),
      .hit       (hit[k]),
      .rid       (evt_rid),
      .clr_first (clr[2*k]),
      .clr_next  (clr[2*k+1]),
      .first_n   (first_n[k]),
      .next_n    (next_n[k]),
      .first_q   (first_q[k]),
      .next_q    (next_q[k]),
      .id_q      (id_q[k])
    );
  end

  // nonfatal-first marker follows the uncorrectable first-error decision
  assign nf_n  = (nf_q & ~clr[ST_NF]) |
                 (is_nonfatal & ~(first_q[1] & ~clr[ST_UF]));
  assign fat_n = (fat_q & ~clr[ST_FAT]) | is_fatal;
  assign en_n  = ctrl_wr ? reg_wdata[NEN-1:0] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nf_q  <= 1'b0;
      fat_q <= 1'b0;
      en_q  <= '0;
      irq   <= 1'b0;
    end else begin
      nf_q  <= nf_nx(nf_n);
      fat_q <= fat_n;
      en_q  <= en_n;
      irq   <= |(en_n & {fat_n, nf_n, first_n[0]});
    end
  end

  function automatic logic nf_nx(input logic v);
    return v;
  endfunction

  assign msg_num   = msg_pair ? MSGN_W'(1) : '0;
  assign ctrl_word = {{(DATA_W-NEN){1'b0}}, en_q};
  assign sts_word  = {msg_num, 20'd0, fat_q, nf_q, 1'b0,
                      next_q[1], first_q[1], next_q[0], first_q[0]};
  assign sid_word  = {id_q[1], id_q[0]};

  rpel_rdmux #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CTRL_OFS(CTRL_OFS),
    .STS_OFS (STS_OFS),
    .SID_OFS (SID_OFS)
  ) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .ctrl_word(ctrl_word),
    .sts_word (sts_word),
    .sid_word (sid_word),
    .rdata    (reg_rdata)
  );
endmodule

// File: rtl/rpel_chk.sv
module rpel_chk #(
  parameter int          ADDR_W   = 12,
  parameter [ADDR_W-1:0] CTRL_OFS = 12'h174,
  parameter [ADDR_W-1:0] STS_OFS  = 12'h178
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_valid,
  input logic [1:0]        evt_sev,
  input logic [15:0]       evt_rid,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              irq,
  input logic [1:0]        first_q,
  input logic [1:0]        next_q,
  input logic              fat_q,
  input logic [2:0]        en_q,
  input logic [31:0]       sid_word
);
  logic w_sts, w_ctrl, cor_evt;
  assign w_sts   = reg_wr && (reg_addr == STS_OFS);
  assign w_ctrl  = reg_wr && (reg_addr == CTRL_OFS);
  assign cor_evt = evt_valid && (evt_sev == 2'd0);

  // R2
  first_log_chk: assert property (@(posedge clk) disable iff (rst)
    (cor_evt && !first_q[0]) |=> (first_q[0] && sid_word[15:0] == $past(evt_rid)));

  // R3
  next_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cor_evt && first_q[0] && !w_sts) |=> (next_q[0] && $stable(sid_word[15:0])));

  // R4
  w0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (first_q[0] && !(w_sts && reg_wdata[0])) |=> first_q[0]);

  // R6
  fatal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_sev[1]) |=> fat_q);

  // R5
  ctrl_rsv_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == CTRL_OFS) |=> (reg_rdata[31:3] == 29'd0));

  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == 3'd0 && !w_ctrl) |=> !irq);
endmodule

bind rp_err_logger rpel_chk #(
  .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STS_OFS(STS_OFS)
) u_rpel_chk (
  .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_sev(evt_sev),
  .evt_rid(evt_rid), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
  .first_q(first_q), .next_q(next_q), .fat_q(fat_q), .en_q(en_q),
  .sid_word(sid_word)
);

// File: tb/test_rp_err_logger.sv
module test_rp_err_logger;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h174;
  localparam logic [11:0] A_STS  = 12'h178;
  localparam logic [11:0] A_SID  = 12'h17C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [1:0]  evt_sev = 2'd0;
  logic [15:0] evt_rid = 16'd0;
  logic        msg_pair = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [11:0] reg_addr = 12'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rp_err_logger i_rp_err_logger (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_sev(evt_sev),
    .evt_rid(evt_rid), .msg_pair(msg_pair), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference
  bit [2:0]  m_en;
  bit        m_cf, m_cn, m_uf, m_un, m_nf, m_fat, m_irq;
  bit [15:0] m_cid, m_uid;
  bit [31:0] m_rd;

  function automatic bit [31:0] m_word(input bit [11:0] a);
    bit [31:0] w = 0;
    if (a == A_CTRL) w = {29'd0, m_en};
    else if (a == A_STS) begin
      w[0] = m_cf; w[1] = m_cn; w[2] = m_uf; w[3] = m_un;
      w[5] = m_nf; w[6] = m_fat;
      w[31:27] = msg_pair ? 5'd1 : 5'd0;
    end else if (a == A_SID) w = {m_uid, m_cid};
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_cf = 0; m_cn = 0; m_uf = 0; m_un = 0; m_nf = 0; m_fat = 0;
      m_cid = 0; m_uid = 0; m_rd = 0; m_irq = 0;
    end else begin
      bit [31:0] c;
      bit cor, unc;
      m_rd = reg_rd ? m_word(reg_addr) : 32'd0;
      c = (reg_wr && reg_addr == A_STS) ? reg_wdata : 32'd0;
      cor = evt_valid && evt_sev == 2'd0;
      unc = evt_valid && evt_sev != 2'd0;
      if (c[0]) m_cf = 0;
      if (c[1]) m_cn = 0;
      if (c[2]) m_uf = 0;
      if (c[3]) m_un = 0;
      if (c[5]) m_nf = 0;
      if (c[6]) m_fat = 0;
      if (cor) begin
        if (m_cf) m_cn = 1; else begin m_cf = 1; m_cid = evt_rid; end
      end
      if (unc) begin
        if (m_uf) m_un = 1;
        else begin
          m_uf = 1; m_uid = evt_rid;
          if (evt_sev == 2'd1) m_nf = 1;
        end
        if (evt_sev[1]) m_fat = 1;
      end
      if (reg_wr && reg_addr == A_CTRL) m_en = reg_wdata[2:0];
      m_irq = (m_en[0] && m_cf) || (m_en[1] && m_nf) || (m_en[2] && m_fat);
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R9 irq actual %0b expected %0b", irq, m_irq);
      end
      checks++;
      if (reg_rdata !== m_rd) begin
        errors++;
        $display("FAIL R11 rdata actual %08h expected %08h", reg_rdata, m_rd);
      end
    end
  end

  task automatic step(input bit ev, input bit [1:0] sv, input bit [15:0] rid,
                      input bit wr, input bit [11:0] a, input bit [31:0] wd);
    evt_valid = ev; evt_sev = sv; evt_rid = rid;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    evt_valid = 0; reg_wr = 0;
  endtask

  task automatic expect_rd(input string tag, input bit [11:0] a, input bit [31:0] exp);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read %03h actual %08h expected %08h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic expect_irq(input string tag, input bit exp);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    expect_rd("R5", A_CTRL, 32'h0);
    expect_rd("R6", A_STS,  32'h0);
    expect_rd("R10", A_SID, 32'h0);
    // R2 first correctable
    step(1, 2'd0, 16'h1234, 0, 0, 0);
    expect_rd("R2", A_STS, 32'h1);
    expect_rd("R2", A_SID, 32'h0000_1234);
    // R3 second correctable
    step(1, 2'd0, 16'h5555, 0, 0, 0);
    expect_rd("R3", A_STS, 32'h3);
    expect_rd("R3", A_SID, 32'h0000_1234);
    // R4 write zero then write one
    step(0, 0, 0, 1, A_STS, 32'h0);
    expect_rd("R4", A_STS, 32'h3);
    step(0, 0, 0, 1, A_STS, 32'h1);
    expect_rd("R4", A_STS, 32'h2);
    // R1 R6 nonfatal then fatal
    step(1, 2'd1, 16'hA0A0, 0, 0, 0);
    expect_rd("R6", A_STS, 32'h26);
    step(1, 2'd2, 16'hBEEF, 0, 0, 0);
    expect_rd("R1", A_STS, 32'h6E);
    expect_rd("R3", A_SID, 32'hA0A0_1234);
    // R10 write to ID register ignored
    step(0, 0, 0, 1, A_SID, 32'hFFFF_FFFF);
    expect_rd("R10", A_SID, 32'hA0A0_1234);
    // R5 R9 enables
    step(0, 0, 0, 1, A_CTRL, 32'hFFFF_FFFF);
    expect_irq("R9", 1'b1);
    expect_rd("R5", A_CTRL, 32'h7);
    step(0, 0, 0, 1, A_STS, 32'hFFFF_FFFF);
    expect_irq("R9", 1'b0);
    expect_rd("R4", A_STS, 32'h0);
    // R8 same-edge correctable
    step(1, 2'd0, 16'h1111, 0, 0, 0);
    expect_irq("R9", 1'b1);
    step(1, 2'd0, 16'h2222, 1, A_STS, 32'h1);
    expect_rd("R8", A_STS, 32'h1);
    expect_rd("R8", A_SID, 32'hA0A0_2222);
    // R8 same-edge uncorrectable, code 3 fatal (R1)
    step(1, 2'd1, 16'h3333, 0, 0, 0);
    expect_rd("R6", A_STS, 32'h25);
    step(1, 2'd3, 16'h4444, 1, A_STS, 32'h4);
    expect_rd("R8", A_STS, 32'h65);
    expect_rd("R8", A_SID, 32'h4444_2222);
    // R7 message number
    msg_pair = 1;
    expect_rd("R7", A_STS, 32'h0800_0065);
    msg_pair = 0;
    expect_rd("R7", A_STS, 32'h0000_0065);
    // R11 unmapped offset
    expect_rd("R11", 12'h100, 32'h0);
    // R9 enable off drops request
    step(0, 0, 0, 1, A_CTRL, 32'h0);
    expect_irq("R9", 1'b0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule